// File: doc/BRIEF.md
# String-Loop Prefix Sequencer

This control block sits in the decode path of a 16-bit processor core. It gathers the one-byte prefixes that come before an opcode. It then resolves which segment the instruction's data accesses use and runs the iteration loop of repeated string operations. Each cycle it may take one byte from the instruction stream. Prefix bytes are stored. A non-prefix byte is the opcode, and it arrives with three side flags: whether the opcode is a string operation, whether it is a compare-type string operation, and whether its addressing uses the base or stack pointer.

Once it has an opcode, the block issues one start pulse per iteration and waits for the datapath to report that the iteration is complete. It keeps its own copy of the count register: it loads the copy at the opcode, pulses a decrement for each completed repeated iteration, and ends the loop at zero. For compare-type operations it can also end the loop early on the zero flag.

A lock prefix holds the bus-lock output for the whole instruction. An interrupt can be accepted only between iterations. When it is, the whole prefix context is saved to a single slot, so the handler's own instructions can be sequenced. A resume pulse later restores the context and continues the loop.

Top module: `prefix_seq`

## Requirements
- R1: With no segment prefix, `seg_sel` reports DS (code 3). If the opcode was flagged as using the base or stack pointer, it reports SS (code 2) instead. Codes: ES=0, CS=1, SS=2, DS=3.
- R2: The bytes 0x26, 0x2E, 0x36 and 0x3E select ES, CS, SS and DS respectively, whatever the pointer flag says. When several segment prefixes come before one opcode, the last one wins.
- R3: An opcode with no repeat prefix, or a non-string opcode, runs exactly one iteration. It raises no `cnt_dec`, and `instr_done` is high in the cycle its `iter_done` arrives.
- R4: 0xF2 or 0xF3 on a string opcode runs `count_in` iterations. `cnt_dec` is high with each `iter_done`, and `instr_done` comes with the last one. A count of zero raises `instr_done` in the opcode's own cycle and issues no `iter_start`.
- R5: On a compare-type string opcode, 0xF3 ends the loop after an iteration that reports `iter_zf`=0, and 0xF2 ends it after one that reports `iter_zf`=1. Other string opcodes ignore `iter_zf`.
- R6: Prefix 0xF0 holds `bus_lock` high from the cycle of the first `iter_start` through the cycle of the final `iter_done`. `bus_lock` is low at every other time, and it is always low while the block is idle.
- R7: Segment, repeat and lock prefixes can all be combined on one instruction, in any order.
- R8: If `irq` is high when a non-final repeated iteration completes, and no context is already saved, then: `irq_ack` pulses in that cycle, the block goes idle with `suspended`=1, and no further `iter_start` is issued. In any other cycle `irq` has no effect.
- R9: While `suspended` is high, other instructions run normally with their own prefixes. A `resume` pulse restores the saved segment, repeat, lock and remaining count, and `iter_start` follows in the next cycle. `resume` with nothing saved is ignored.
- R10: `iter_start` is a one-cycle pulse. It comes in the cycle after an opcode is accepted, and in the cycle after each `iter_done` that continues the loop. Only one iteration is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A byte is offered on `byte_in` |
| byte_in | input | 8 | Prefix or opcode byte |
| op_string | input | 1 | The opcode is a string operation |
| op_cmp | input | 1 | The opcode is a compare or scan string operation |
| op_bpsp | input | 1 | The opcode addresses memory through the base or stack pointer |
| count_in | input | CW | Count register value, sampled with the opcode |
| iter_done | input | 1 | The datapath has completed the current iteration |
| iter_zf | input | 1 | Zero flag of the completed iteration |
| irq | input | 1 | Interrupt request |
| resume | input | 1 | Restore the saved context and continue its loop |
| seg_sel | output | 2 | Effective segment (ES=0, CS=1, SS=2, DS=3) |
| bus_lock | output | 1 | Bus lock request |
| iter_start | output | 1 | Start pulse for one iteration |
| cnt_dec | output | 1 | Decrement the count register |
| instr_done | output | 1 | Instruction finished |
| irq_ack | output | 1 | Interrupt accepted between iterations |
| suspended | output | 1 | A repeated instruction's context is saved |
| busy | output | 1 | An instruction is executing |

## Verification
Two events compete in the same cycle: an iteration completing while an interrupt is requested, and the loop's own end condition, which is either the final count or an early compare exit. The bench raises `irq` on randomly chosen iterations. The chosen iteration is sometimes the last one, sometimes one that ends the loop early on the zero flag, and sometimes the completion of a plain instruction run while a context is already saved. For each of these cases, the bench's loop model predicts whether the block must produce `instr_done`, `irq_ack`, or neither, and compares that against both outputs in that same cycle. After an accepted interrupt, the bench resumes the loop and checks the restored segment, lock state and remaining iteration count.

// File: rtl/prefix_seq.sv
module prefix_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  input  logic          op_string,
  input  logic          op_cmp,
  input  logic          op_bpsp,
  input  logic [CW-1:0] count_in,
  input  logic          iter_done,
  input  logic          iter_zf,
  input  logic          irq,
  input  logic          resume,
  output logic [1:0]    seg_sel,
  output logic          bus_lock,
  output logic          iter_start,
  output logic          cnt_dec,
  output logic          instr_done,
  output logic          irq_ack,
  output logic          suspended,
  output logic          busy
);

  localparam logic [1:0] SEG_SS = 2'd2;
  localparam logic [1:0] SEG_DS = 2'd3;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_GO, S_WAIT} st_t;
  st_t st;

  logic          ovr_v, rep_on, rep_eq, lock_p, bp_q, cmp_q;
  logic [1:0]    ovr_seg;
  logic [CW-1:0] cnt;

  logic          sv_v, sv_ovr_v, sv_rep_eq, sv_lock, sv_bp, sv_cmp;
  logic [1:0]    sv_ovr_seg;
  logic [CW-1:0] sv_cnt;

  logic is_seg, is_lock, is_rep, is_pfx;
  logic take_res, op_acc, skip0, early, last_it, fin, take_irq;

  // segment overrides share the pattern 001x_x110, register in bits 4:3
  assign is_seg  = (byte_in[7:5] == 3'b001) && (byte_in[2:0] == 3'b110);
  assign is_lock = (byte_in == 8'hF0);
  assign is_rep  = (byte_in[7:1] == 7'b1111_001);
  assign is_pfx  = is_seg | is_lock | is_rep;

  assign take_res = (st == S_IDLE) && resume && sv_v;
  assign op_acc   = (st == S_IDLE) && byte_valid && !take_res && !is_pfx;
  assign skip0    = op_acc && rep_on && op_string && (count_in == '0);
  assign early    = cmp_q && (rep_eq ? !iter_zf : iter_zf);
  assign last_it  = !rep_on || (cnt == ONE) || early;
  assign fin      = (st == S_WAIT) && iter_done && last_it;
  assign take_irq = (st == S_WAIT) && iter_done && !last_it && irq && !sv_v;

  assign seg_sel    = ovr_v ? ovr_seg : (bp_q ? SEG_SS : SEG_DS);
  assign busy       = (st != S_IDLE);
  assign bus_lock   = lock_p && busy;
  assign iter_start = (st == S_GO);
  assign cnt_dec    = (st == S_WAIT) && iter_done && rep_on;
  assign instr_done = fin | skip0;
  assign irq_ack    = take_irq;
  assign suspended  = sv_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ovr_v      <= 1'b0;
      ovr_seg    <= 2'd0;
      rep_on     <= 1'b0;
      rep_eq     <= 1'b0;
      lock_p     <= 1'b0;
      bp_q       <= 1'b0;
      cmp_q      <= 1'b0;
      cnt        <= '0;
      sv_v       <= 1'b0;
      sv_ovr_v   <= 1'b0;
      sv_ovr_seg <= 2'd0;
      sv_rep_eq  <= 1'b0;
      sv_lock    <= 1'b0;
      sv_bp      <= 1'b0;
      sv_cmp     <= 1'b0;
      sv_cnt     <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take_res) begin
            ovr_v   <= sv_ovr_v;
            ovr_seg <= sv_ovr_seg;
            rep_on  <= 1'b1;
            rep_eq  <= sv_rep_eq;
            lock_p  <= sv_lock;
            bp_q    <= sv_bp;
            cmp_q   <= sv_cmp;
            cnt     <= sv_cnt;
            sv_v    <= 1'b0;
            st      <= S_GO;
          end else if (byte_valid) begin
            if (is_seg) begin
              ovr_v   <= 1'b1;
              ovr_seg <= byte_in[4:3];
            end
            if (is_lock) lock_p <= 1'b1;
            if (is_rep) begin
              rep_on <= 1'b1;
              rep_eq <= byte_in[0];
            end
            if (!is_pfx) begin
              bp_q  <= op_bpsp;
              cmp_q <= op_cmp;
              cnt   <= count_in;
              if (skip0) begin
                ovr_v  <= 1'b0;
                rep_on <= 1'b0;
                lock_p <= 1'b0;
              end else begin
                rep_on <= rep_on & op_string;
                st     <= S_GO;
              end
            end
          end
        end
        S_GO: st <= S_WAIT;
        S_WAIT: begin
          if (iter_done) begin
            if (rep_on) cnt <= cnt - ONE;
            if (fin || take_irq) begin
              ovr_v  <= 1'b0;
              rep_on <= 1'b0;
              lock_p <= 1'b0;
              st     <= S_IDLE;
            end else begin
              st <= S_GO;
            end
            if (take_irq) begin
              sv_v       <= 1'b1;
              sv_ovr_v   <= ovr_v;
              sv_ovr_seg <= ovr_seg;
              sv_rep_eq  <= rep_eq;
              sv_lock    <= lock_p;
              sv_bp      <= bp_q;
              sv_cmp     <= cmp_q;
              sv_cnt     <= cnt - ONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    iter_start |=> !iter_start); // R10
  AST_DEC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> iter_done); // R4
  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_lock); // R6
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && busy) |=> !bus_lock); // R6
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !instr_done); // R8
  AST_ACK_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (suspended && !busy)); // R8
  AST_RESUME_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && suspended && !busy) |=> iter_start); // R9
  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(seg_sel)); // R2

endmodule

// File: tb/prefix_seq_tb_top.sv
module prefix_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, byte_valid, op_string, op_cmp, op_bpsp;
  logic [7:0] byte_in;
  logic [15:0] count_in;
  logic iter_done, iter_zf, irq, resume;
  logic [1:0] seg_sel;
  logic bus_lock, iter_start, cnt_dec, instr_done, irq_ack, suspended, busy;

  prefix_seq #(.CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
    .op_string(op_string), .op_cmp(op_cmp), .op_bpsp(op_bpsp), .count_in(count_in),
    .iter_done(iter_done), .iter_zf(iter_zf), .irq(irq), .resume(resume),
    .seg_sel(seg_sel), .bus_lock(bus_lock), .iter_start(iter_start), .cnt_dec(cnt_dec),
    .instr_done(instr_done), .irq_ack(irq_ack), .suspended(suspended), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  logic last_done;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_iters(bit rep, bit eq, bit str, bit cmp, int cnt, logic [15:0] zf);
    if (!(rep && str)) return 1;
    if (cnt == 0) return 0;
    for (int i = 0; i < cnt; i++)
      if (cmp && (eq ? !zf[i] : zf[i])) return i + 1;
    return cnt;
  endfunction

  function automatic int exp_seg(int ovr, bit bp);
    if (ovr >= 0) return ovr;
    return bp ? 2 : 3;
  endfunction

  task automatic send(input logic [7:0] b, input bit str, input bit cmp, input bit bp, input int cnt);
    byte_valid = 1'b1; byte_in = b; op_string = str; op_cmp = cmp; op_bpsp = bp;
    count_in = 16'(cnt);
    @(negedge clk);
    last_done = instr_done;
    step();
    byte_valid = 1'b0;
  endtask

  task automatic simple_op(input int ovr, input bit bp, input bit irq_on, input bit exp_susp);
    if (ovr >= 0) send(8'h26 | 8'(ovr * 8), 0, 0, 0, 0);
    send(8'h90, 0, 0, bp, 5);
    @(negedge clk);
    chk(iter_start == 1'b1, "R3 single start", int'(iter_start), 1);
    chk(int'(seg_sel) == exp_seg(ovr, bp), "R2 segment of plain op", int'(seg_sel), exp_seg(ovr, bp));
    step();
    iter_done = 1'b1; iter_zf = 1'b0; irq = irq_on;
    @(negedge clk);
    chk(instr_done == 1'b1, "R3 done after one iteration", int'(instr_done), 1);
    chk(cnt_dec == 1'b0, "R3 no decrement", int'(cnt_dec), 0);
    chk(irq_ack == 1'b0, "R8 irq ignored on single op", int'(irq_ack), 0);
    step();
    iter_done = 1'b0; irq = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R3 idle after op", int'(busy), 0);
    chk(suspended == exp_susp, "R9 saved context kept", int'(suspended), int'(exp_susp));
    step();
  endtask

  task automatic run(input int ovr, input int ovr_pre, input int rep, input bit lk,
                     input bit str, input bit cmp, input bit bp, input int cnt,
                     input logic [15:0] zf, input int irq_at, input int order, input int maxd);
    int ni, es, d;
    bit repact, lastk, tk;
    ni = exp_iters(rep != 0, rep == 3, str, cmp, cnt, zf);
    repact = (rep != 0) && str;
    es = exp_seg(ovr, bp);
    if (ovr >= 0 && ovr_pre >= 0) send(8'h26 | 8'(ovr_pre * 8), 0, 0, 0, 0);
    for (int j = 0; j < 3; j++) begin
      case ((j + order) % 3)
        0: if (ovr >= 0) send(8'h26 | 8'(ovr * 8), 0, 0, 0, 0);
        1: if (rep != 0) send((rep == 3) ? 8'hF3 : 8'hF2, 0, 0, 0, 0);
        default: if (lk) send(8'hF0, 0, 0, 0, 0);
      endcase
    end
    send(8'hA6, str, cmp, bp, cnt);
    if (ni == 0) begin
      chk(last_done == 1'b1, "R4 zero count done at opcode", int'(last_done), 1);
      @(negedge clk);
      chk(!busy && !iter_start, "R4 zero count no iteration", int'(iter_start), 0);
      chk(bus_lock == 1'b0, "R6 no lock on zero count", int'(bus_lock), 0);
      step();
      return;
    end
    chk(last_done == 1'b0, "R4 no early done", int'(last_done), 0);
    for (int k = 0; k < ni; k++) begin
      @(negedge clk);
      chk(iter_start == 1'b1, "R10 iteration start", int'(iter_start), 1);
      chk(int'(seg_sel) == es, "R1 R2 R7 effective segment", int'(seg_sel), es);
      chk(bus_lock == lk, "R6 lock during start", int'(bus_lock), int'(lk));
      step();
      d = $urandom_range(0, maxd);
      for (int w = 0; w < d; w++) begin
        @(negedge clk);
        chk(iter_start == 1'b0, "R10 one outstanding", int'(iter_start), 0);
        chk(bus_lock == lk, "R6 lock while waiting", int'(bus_lock), int'(lk));
        step();
      end
      lastk = (k == ni - 1);
      tk = (k == irq_at) && !lastk && !suspended;
      iter_done = 1'b1; iter_zf = zf[k]; irq = (k == irq_at);
      @(negedge clk);
      chk(cnt_dec == repact, "R4 decrement per iteration", int'(cnt_dec), int'(repact));
      chk(instr_done == lastk, "R5 R4 loop end", int'(instr_done), int'(lastk));
      chk(irq_ack == tk, "R8 interrupt acceptance", int'(irq_ack), int'(tk));
      chk(bus_lock == lk, "R6 lock to final write", int'(bus_lock), int'(lk));
      step();
      iter_done = 1'b0; irq = 1'b0;
      if (lastk) begin
        @(negedge clk);
        chk(!busy && !bus_lock, "R6 released after done", int'(bus_lock), 0);
        step();
      end
      if (tk) begin
        @(negedge clk);
        chk(suspended && !busy, "R8 suspended idle", int'(suspended), 1);
        chk(bus_lock == 1'b0, "R6 lock dropped while suspended", int'(bus_lock), 0);
        step();
        irq = 1'b1;
        for (int w = 0; w < 2; w++) begin
          @(negedge clk);
          chk(!iter_start && !irq_ack, "R8 no action while idle", int'(iter_start), 0);
          step();
        end
        irq = 1'b0;
        simple_op($urandom_range(0, 1) ? 0 : -1, 1'b1, 1'b1, 1'b1);
        resume = 1'b1;
        step();
        resume = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; byte_valid = 1'b0; byte_in = 8'h00; op_string = 1'b0; op_cmp = 1'b0;
    op_bpsp = 1'b0; count_in = 16'd0; iter_done = 1'b0; iter_zf = 1'b0; irq = 1'b0; resume = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !iter_start && !bus_lock && !suspended, "R10 reset idle", int'(busy), 0);
    chk(seg_sel == 2'd3, "R1 reset segment DS", int'(seg_sel), 3);
    step();

    resume = 1'b1;
    step();
    resume = 1'b0;
    @(negedge clk);
    chk(!busy && !iter_start, "R9 resume with nothing saved ignored", int'(iter_start), 0);
    step();

    simple_op(-1, 1'b0, 1'b0, 1'b0);
    simple_op(-1, 1'b1, 1'b1, 1'b0);
    for (int s = 0; s < 4; s++) run(s, -1, 0, 0, 1, 0, 1, 4, 16'h0, -1, 0, 1);
    run(0, 3, 0, 0, 0, 0, 0, 0, 16'h0, -1, 0, 0);
    run(2, 1, 0, 0, 0, 0, 0, 0, 16'h0, -1, 0, 0);
    run(-1, -1, 3, 0, 0, 0, 0, 6, 16'h0, -1, 0, 1);
    run(-1, -1, 3, 1, 1, 0, 0, 0, 16'h0, -1, 0, 1);
    run(-1, -1, 3, 0, 1, 0, 0, 1, 16'h0, -1, 0, 1);
    run(-1, -1, 2, 0, 1, 0, 0, 5, 16'hFFFF, -1, 0, 0);
    run(-1, -1, 3, 0, 1, 1, 0, 8, 16'h0007, -1, 0, 1);
    run(-1, -1, 2, 0, 1, 1, 1, 8, 16'h0004, -1, 0, 1);
    run(-1, -1, 3, 0, 1, 1, 0, 8, 16'h0007, 3, 0, 0);
    run(-1, -1, 3, 1, 0, 0, 0, 4, 16'h0, -1, 0, 2);
    run(1, -1, 3, 1, 1, 0, 1, 3, 16'h0, 2, 0, 0);
    for (int o = 0; o < 3; o++) run(o, -1, 2 + (o % 2), 1, 1, 0, 1, 5, 16'h0, 1, o, 1);
    run(0, -1, 3, 1, 1, 1, 0, 6, 16'hFFFF, 0, 2, 0);

    for (int n = 0; n < 300; n++) begin
      int ovr, pre, rep, cnt, ia;
      bit lk, str, cmp, bp;
      logic [15:0] zf;
      ovr = int'($urandom_range(0, 4)) - 1;
      pre = int'($urandom_range(0, 4)) - 1;
      case ($urandom_range(0, 2))
        0: rep = 0;
        1: rep = 2;
        default: rep = 3;
      endcase
      lk = 1'($urandom_range(0, 1));
      str = ($urandom_range(0, 3) != 0);
      cmp = 1'($urandom_range(0, 1));
      bp = 1'($urandom_range(0, 1));
      cnt = $urandom_range(0, 9);
      zf = 16'($urandom);
      if ($urandom_range(0, 1) == 1) zf = cmp ? ((rep == 3) ? 16'hFFFF : 16'h0000) : zf;
      ia = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 9)) : -1;
      run(ovr, pre, rep, lk, str, cmp, bp, cnt, zf, ia, $urandom_range(0, 2), 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule